// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM of 32K by 8 bits. The host asks for one byte at a time: it raises a request for one clock together with a read/write flag, a 15-bit address and, for writes, a data byte. The controller then plays out the active-low chip-enable, write-enable and output-enable strobes and drives the data bus, and it raises a one-cycle ready pulse when the access has finished. On a read, the returned byte sits on a holding register.

Every interval is a whole number of clock cycles, worked out during elaboration from two parameters: the clock period and the speed grade of the memory (70, 85, 120 or 150 ns access). A write keeps chip enable low first and turns on the data drivers only after output enable has been high long enough for the memory to release the bus. It then forms the write pulse on write enable alone and keeps chip enable low for the recovery time after write enable rises. A read holds chip enable and output enable low for at least the access time and latches the bus on the edge that ends that window.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held, and after it until a request arrives, all three strobes are high (inactive), the data drivers are off and ready is low.
- R2: A read keeps chip enable and output enable low and write enable high for at least the grade's access time (70 ns at the default grade). It captures the bus at the end of that window into the read-data register.
- R3: In a write, chip enable falls while write enable is still high, and output enable stays high for the whole write. Write enable is only low while chip enable is low. The data drivers turn on only after output enable has been high for at least the output turn-off time (25 ns at the default grade).
- R4: The write-enable low pulse lasts at least the write pulse time (55 ns at the default grade). The driven data is stable for at least the data setup time (30 ns) before write enable rises, and it is still driven at that rise.
- R5: Writes are ended by write enable. Chip enable stays low for at least the write recovery time (5 ns) after write enable rises.
- R6: The memory address changes only in a cycle that follows one in which chip enable was high. It equals the address of the accepted request for the whole access.
- R7: Ready is high for exactly one cycle per completed access.
- R8: A request is accepted only while the controller is idle. A request raised during an access is dropped: no memory cycle is run for it and no ready is given.
- R9: Output enable and write enable are never low together, and the data drivers are never on while output enable is low.
- R10: Each interval lasts max(1, ceil(ns / clock period)) cycles. Both a read and a write last at least the grade's cycle time. At 8 ns and grade 70, ready follows the accepting edge by 9 cycles for a read and by 12 cycles for a write (4 turn-off, 7 pulse, 1 recovery).
- R11: The read-data register keeps the last byte read until the next read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address of the request |
| req_wdata | input | 8 | Data byte for a write |
| rdy | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte returned by the last read |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_addr | output | 15 | Address to the memory |
| sram_dq_o | output | 8 | Data driven toward the memory |
| sram_dq_i | input | 8 | Data arriving from the memory bus |
| sram_dq_oe | output | 1 | Enable of the data drivers toward the memory |

## Verification
The bench memory model returns the inverted byte until the access time has passed since the last strobe or address change. A controller that samples even one cycle early therefore reads back wrong data. The model also times each write-enable pulse, the data stability ahead of its rise, the gap between write enable rising and chip enable rising, and the gap between output enable rising and the drivers turning on. A shortened interval or swapped state order shows up as a timing miscompare. A request raised mid-write is followed by read-backs of both addresses and a count of ready pulses, so a controller that accepts work while busy writes a stray byte or gives an extra ready. The addresses 0 and 7FFF check that the address path does not truncate, and a write placed after a read checks that the read-data register is not disturbed.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_REC   = 3'd4
    } seq_state_e;

    typedef enum logic [2:0] {
        TP_ACCESS,
        TP_WPULSE,
        TP_DSETUP,
        TP_WREC,
        TP_HIZ
    } tparam_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STB_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // Nanosecond value of one timing parameter for a speed grade.
    function automatic int grade_ns(input int speed, input tparam_e which);
        int v;
        v = speed;
        case (which)
            TP_ACCESS: v = speed;
            TP_WPULSE: v = (speed <= 70) ? 55 : (speed <= 85) ? 65 : (speed <= 120) ? 85 : 90;
            TP_DSETUP: v = (speed <= 70) ? 30 : (speed <= 85) ? 35 : (speed <= 120) ? 45 : 50;
            TP_WREC:   v = 5;
            TP_HIZ:    v = (speed <= 85) ? 25 : (speed <= 120) ? 35 : 50;
            default:   v = speed;
        endcase
        return v;
    endfunction

    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Strobe pattern held on the memory pins during each state.
    function automatic strobe_t strobe_of(input seq_state_e s);
        strobe_t t;
        t = STB_IDLE;
        case (s)
            ST_RD_ACC:   t = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            ST_WR_TURN:  t = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
            ST_WR_PULSE: t = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            ST_WR_REC:   t = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
            default:     t = STB_IDLE;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sram_ivl_timer.sv
module sram_ivl_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_len,
    output logic          expired
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_len - CW'(1);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign expired = (remain == '0);

    AST_LOAD_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_len != '0)); // R10

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW      = 4,
    parameter int N_RD    = 9,
    parameter int N_HIZ   = 4,
    parameter int N_PULSE = 7,
    parameter int N_WR    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_len,
    output logic          accept,
    output logic          capture,
    output logic          rdy,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic          drive
);

    seq_state_e st, nxt;
    strobe_t    stb;
    logic       done_nxt;

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_len = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        done_nxt = 1'b0;
        case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_write) begin
                        nxt      = ST_WR_TURN;
                        load_len = CW'(N_HIZ);
                    end else begin
                        nxt      = ST_RD_ACC;
                        load_len = CW'(N_RD);
                    end
                end
            end
            ST_RD_ACC: begin
                if (expired) begin
                    nxt      = ST_IDLE;
                    capture  = 1'b1;
                    done_nxt = 1'b1;
                end
            end
            ST_WR_TURN: begin
                if (expired) begin
                    nxt      = ST_WR_PULSE;
                    load     = 1'b1;
                    load_len = CW'(N_PULSE);
                end
            end
            ST_WR_PULSE: begin
                if (expired) begin
                    nxt      = ST_WR_REC;
                    load     = 1'b1;
                    load_len = CW'(N_WR);
                end
            end
            ST_WR_REC: begin
                if (expired) begin
                    nxt      = ST_IDLE;
                    done_nxt = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            stb <= STB_IDLE;
            rdy <= 1'b0;
        end else begin
            st  <= nxt;
            stb <= strobe_of(nxt);
            rdy <= done_nxt;
        end
    end

    assign ce_n  = stb.ce_n;
    assign we_n  = stb.we_n;
    assign oe_n  = stb.oe_n;
    assign drive = stb.drive;

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n)); // R9
    AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> !ce_n); // R3
    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !rdy); // R7
    AST_WE_RISE_CE_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> !ce_n); // R5
    AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        accept |-> (ce_n && we_n && oe_n)); // R8

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic          drive,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [DW-1:0] dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe,
    output logic [DW-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            dq_o     <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                dq_o     <= req_wdata;
            end
            if (capture) begin
                rd_data <= dq_i;
            end
        end
    end

    assign dq_oe = drive;

    AST_ADDR_MOVES_CE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem_addr) |-> $past(ce_n)); // R6
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_o)); // R4
    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (oe_n && !ce_n)); // R9

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 8,
    parameter int SPEED_NS = 70,
    parameter int AW       = 15,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rdy,
    output logic [DW-1:0] rd_data,
    output logic          sram_ce_n,
    output logic          sram_we_n,
    output logic          sram_oe_n,
    output logic [AW-1:0] sram_addr,
    output logic [DW-1:0] sram_dq_o,
    input  logic [DW-1:0] sram_dq_i,
    output logic          sram_dq_oe
);

    localparam int N_ACC   = ns_to_cycles(grade_ns(SPEED_NS, TP_ACCESS), CLK_NS);
    localparam int N_HIZ   = ns_to_cycles(grade_ns(SPEED_NS, TP_HIZ), CLK_NS);
    localparam int N_WP    = ns_to_cycles(grade_ns(SPEED_NS, TP_WPULSE), CLK_NS);
    localparam int N_DS    = ns_to_cycles(grade_ns(SPEED_NS, TP_DSETUP), CLK_NS);
    localparam int N_WR    = ns_to_cycles(grade_ns(SPEED_NS, TP_WREC), CLK_NS);
    localparam int N_RD    = N_ACC;
    localparam int N_PULSE = imax(imax(N_WP, N_DS), N_ACC - N_HIZ - N_WR);
    localparam int N_MAX   = imax(imax(N_RD, N_HIZ), imax(N_PULSE, N_WR));
    localparam int CW      = $clog2(N_MAX + 1);

    logic          load;
    logic [CW-1:0] load_len;
    logic          expired;
    logic          accept;
    logic          capture;
    logic          drive;

    sram_ivl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_len (load_len),
        .expired  (expired)
    );

    sram_seq_fsm #(
        .CW      (CW),
        .N_RD    (N_RD),
        .N_HIZ   (N_HIZ),
        .N_PULSE (N_PULSE),
        .N_WR    (N_WR)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .expired   (expired),
        .load      (load),
        .load_len  (load_len),
        .accept    (accept),
        .capture   (capture),
        .rdy       (rdy),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .drive     (drive)
    );

    sram_dq_path #(.AW(AW), .DW(DW)) u_dq (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .drive     (drive),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .dq_i      (sram_dq_i),
        .mem_addr  (sram_addr),
        .dq_o      (sram_dq_o),
        .dq_oe     (sram_dq_oe),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/sram_async_ctl_tb.sv
`timescale 1ns/1ps
module sram_async_ctl_tb_top;

    localparam int TB_CLK = 8;
    localparam int TB_ACC = 70;
    localparam int TB_WP  = 55;
    localparam int TB_DS  = 30;
    localparam int TB_WR  = 5;
    localparam int TB_HIZ = 25;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + TB_CLK - 1) / TB_CLK;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int LAT_RD = cyc(TB_ACC) + 1;
    localparam int LAT_WR = cyc(TB_HIZ)
                          + mx(mx(cyc(TB_WP), cyc(TB_DS)), cyc(TB_ACC) - cyc(TB_HIZ) - cyc(TB_WR))
                          + cyc(TB_WR) + 1;

    typedef struct packed {
        logic        wr;
        logic [14:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{wr: 1'b1, addr: 15'h0001, data: 8'h3C},
        '{wr: 1'b1, addr: 15'h7FFF, data: 8'hC3},
        '{wr: 1'b1, addr: 15'h0000, data: 8'h5A},
        '{wr: 1'b0, addr: 15'h0001, data: 8'h00},
        '{wr: 1'b0, addr: 15'h7FFF, data: 8'h00},
        '{wr: 1'b1, addr: 15'h0012, data: 8'hFF},
        '{wr: 1'b0, addr: 15'h0000, data: 8'h00},
        '{wr: 1'b0, addr: 15'h0012, data: 8'h00},
        '{wr: 1'b1, addr: 15'h0001, data: 8'h00},
        '{wr: 1'b0, addr: 15'h0001, data: 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [14:0] req_addr;
    logic [7:0]  req_wdata;
    logic        rdy;
    logic [7:0]  rd_data;
    logic        sram_ce_n, sram_we_n, sram_oe_n;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_o;
    logic [7:0]  sram_dq_i;
    logic        sram_dq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit live   = 1'b0;

    always #(TB_CLK / 2) clk = ~clk;

    sram_async_ctl dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rdy        (rdy),
        .rd_data    (rd_data),
        .sram_ce_n  (sram_ce_n),
        .sram_we_n  (sram_we_n),
        .sram_oe_n  (sram_oe_n),
        .sram_addr  (sram_addr),
        .sram_dq_o  (sram_dq_o),
        .sram_dq_i  (sram_dq_i),
        .sram_dq_oe (sram_dq_oe)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [64];
    logic [7:0] shadow [64];
    time rd_start = 0, ce_fall = 0, we_fall = 0, data_t = 0, oe_hi_t = 0, we_rise = 0;
    bit  wr_flag = 1'b0;
    logic mdl_valid = 1'b0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 8'h00;
            shadow[i] = 8'h00;
        end
    end

    always @(sram_ce_n or sram_oe_n or sram_addr) rd_start = $time;
    always @(negedge sram_ce_n) ce_fall = $time;
    always @(posedge sram_oe_n) oe_hi_t = $time;
    always @(sram_dq_o or posedge sram_dq_oe) data_t = $time;

    always begin
        #1;
        mdl_valid = (($time - rd_start) >= TB_ACC);
        if (live && sram_dq_oe && !sram_oe_n)
            check(1'b0, "R9 drive with oe low", 1, 0);
        if (live && !sram_we_n && !sram_oe_n)
            check(1'b0, "R9 oe and we low", 1, 0);
    end

    assign sram_dq_i = (!sram_ce_n && !sram_oe_n && sram_we_n && mdl_valid)
                     ? mem[sram_addr[5:0]] : ~mem[sram_addr[5:0]];

    always @(negedge sram_we_n) begin
        we_fall = $time;
        if (live) check(!sram_ce_n && sram_oe_n, "R3 we fall under ce, oe high", {sram_ce_n, sram_oe_n}, 2'b01);
    end

    always @(posedge sram_dq_oe) begin
        if (live) check(($time - oe_hi_t) >= TB_HIZ, "R3 turn-off before drive", $time - oe_hi_t, TB_HIZ);
    end

    always @(posedge sram_we_n) begin
        time t;
        t = $time;
        #1;
        if (live) begin
            check((t - we_fall) >= TB_WP, "R4 write pulse", t - we_fall, TB_WP);
            check(((t - data_t) >= TB_DS) && sram_dq_oe, "R4 data setup", t - data_t, TB_DS);
            mem[sram_addr[5:0]] = sram_dq_o;
            we_rise = t;
            wr_flag = 1'b1;
        end
    end

    always @(posedge sram_ce_n) begin
        if (live) begin
            if (wr_flag) begin
                check(($time - we_rise) >= TB_WR, "R5 recovery", $time - we_rise, TB_WR);
                wr_flag = 1'b0;
            end else begin
                check(($time - ce_fall) >= TB_ACC, "R2 read window", $time - ce_fall, TB_ACC);
            end
        end
    end

    // ---------------- host side ----------------
    task automatic do_op(input logic wr, input logic [14:0] a, input logic [7:0] d,
                         output logic [7:0] q);
        int lat;
        bit seen;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        seen = 1'b0;
        check(sram_addr == a && !sram_ce_n, "R6 address", sram_addr, a);
        while (!seen && lat < 100) begin
            if (rdy) seen = 1'b1;
            else begin
                @(negedge clk);
                lat++;
                if (!sram_ce_n) check(sram_addr == a, "R6 address held", sram_addr, a);
            end
        end
        check(lat == (wr ? LAT_WR : LAT_RD), "R10 latency", lat, wr ? LAT_WR : LAT_RD);
        q = rd_data;
        @(negedge clk);
        check(!rdy, "R7 ready one cycle", rdy, 0);
    endtask

    initial begin
        #(TB_CLK * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic [7:0] hold;
        int rdy_cnt;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (4) @(negedge clk);
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rdy} == 5'b11100,
              "R1 reset state", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rdy}, 5'b11100);
        rst = 1'b0;
        live = 1'b1;
        repeat (3) @(negedge clk);
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rdy} == 5'b11100,
              "R1 idle after reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe, rdy}, 5'b11100);

        // Vector table: writes update the shadow, reads compare against it (R2, R4).
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].wr, VECS[i].addr, VECS[i].data, q);
            if (VECS[i].wr) shadow[VECS[i].addr[5:0]] = VECS[i].data;
            else check(q == shadow[VECS[i].addr[5:0]], "R2 read data", q, shadow[VECS[i].addr[5:0]]);
        end

        // R11: a write does not disturb the read-data register.
        do_op(1'b0, 15'h7FFF, 8'h00, q);
        hold = q;
        check(q == 8'hC3, "R2 read top address", q, 8'hC3);
        do_op(1'b1, 15'h0021, 8'h44, q);
        shadow[6'h21] = 8'h44;
        check(rd_data == hold, "R11 read data held across write", rd_data, hold);

        // R8: request during a write is dropped.
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0020; req_wdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_cnt = 0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0021; req_wdata = 8'h99;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (rdy) rdy_cnt++;
            @(negedge clk);
        end
        shadow[6'h20] = 8'h77;
        check(rdy_cnt == 1, "R8 one ready for busy window", rdy_cnt, 1);
        do_op(1'b0, 15'h0021, 8'h00, q);
        check(q == 8'h44, "R8 dropped write left memory", q, 8'h44);
        do_op(1'b0, 15'h0020, 8'h00, q);
        check(q == 8'h77, "R8 accepted write landed", q, 8'h77);

        // Back-to-back read right after write, then idle strobes again (R1, R10).
        do_op(1'b1, 15'h003F, 8'hA6, q);
        do_op(1'b0, 15'h003F, 8'h00, q);
        check(q == 8'hA6, "R10 back-to-back read", q, 8'hA6);
        check({sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe} == 4'b1110,
              "R1 strobes idle between accesses", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b1110);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule